// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block gathers a bank of external interrupt lines and delivers each one to a single processor core on a single output pin of that core. Every source is conditioned on its own: it can be sensed as a level (high or low) or as an edge (rising, falling, or both). Edge-sensed sources hold their pending state in a latch until software clears it. Software can also set that latch to send an interrupt from one core to another.

All configuration lives in a register file on a plain 32-bit memory-mapped bus. Each cycle carries one write strobe, a byte address and write data. Read data follows the address combinationally. Masking is changed only through a write-one-to-enable word and a write-one-to-disable word, so several agents can change different sources without a read-modify-write race. Each core output line is the registered OR of every pending, enabled source that is routed to that core and pin.

Top module: `shared_irq_router`

## Requirements
- R1: After reset every source is level-sensed, active high, masked and not pending, every pin map is invalid, every core map selects core 0, and all core outputs are low. The polarity word (0x100) reads all ones, and the trigger (0x180), mask (0x280) and pending (0x400) words read zero.
- R2: The word at 0x000 reads NUM_SRC/8-1 in bits [23:16] and NUM_CORE-1 in bits [7:0], with every other bit zero.
- R3: For a level source (trigger bit 0 in the word at 0x180+4w), the pending bit equals the input when the polarity bit (0x100+4w) is 1, and its inverse when it is 0. The bit is visible in the pending word two clock edges after the input changes.
- R4: For an edge source (trigger bit 1) with dual-edge off (0x200+4w), a rising input edge (polarity 1) or a falling input edge (polarity 0) sets pending. Pending then stays set after the input returns, until it is cleared.
- R5: With the dual-edge bit set on an edge source, both input edges set pending whatever the polarity bit holds.
- R6: Writing the word at 0x300+4w enables each source whose data bit is 1. Writing 0x380+4w disables each source whose data bit is 1. Zero bits leave those sources unchanged. The mask reads back at 0x280+4w.
- R7: A write to 0x004 with bit 31 = 1 sets, and with bit 31 = 0 clears, the pending latch of the source numbered in bits [7:0]. It affects only edge sources; it changes no level source and does nothing for a number at or above NUM_SRC.
- R8: The pin map of source i is at 0x800+4i (bit 31 = valid, low bits = pin) and its core map is at 0xC00+4i (low bits = core index). Output bit core*NUM_PIN+pin is high exactly when some source with that mapping is pending, enabled and has a valid pin map.
- R9: Each core output is registered. It changes on the clock edge after the edge that changed the pending or mask state feeding it, and it is low whenever no source was both pending and enabled in the previous cycle.
- R10: Writing a new core index to a source's core map reroutes it to that core. A write of an index at or above NUM_CORE is ignored, and the stored index reads back.
- R11: The pending word at 0x400+4w shows pending state whether or not the source is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_SRC | Asynchronous interrupt source lines |
| bus_wen | input | 1 | Write strobe for the current bus address |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| core_irq | output | NUM_CORE*NUM_PIN | Interrupt lines, bit core*NUM_PIN+pin |

## Verification
The assertions check four behaviours on every cycle. The mask changes only in the cycle after a set-mask or clear-mask write. An edge latch that is not being cleared stays set. A software set always reaches an edge source, and it leaves level sources untouched. The outputs fall whenever nothing was both pending and enabled, and every live source drives its own mapped output. The bench scenarios cover what no single-cycle property expresses: the polarity and edge sweeps over each source, the exact latency through the synchronizer, the effect of rerouting and of invalid pin maps, and the readback of the configuration word.

// File: rtl/sirq_pkg.sv
`timescale 1ns/1ps
// Package: register group codes for the shared interrupt router.
// Assumes a 12-bit byte address. Bits [11:7] select a word group and
// bits [6:2] select the word in it. When bit 11 is set, bit 10 selects
// the per-source pin map (0) or core map (1), and bits [9:2] select the
// source.
package sirq_pkg;
    localparam logic [4:0] GRP_CTL  = 5'h00; // 0x000 config, 0x004 write-edge
    localparam logic [4:0] GRP_POL  = 5'h02; // 0x100 polarity words
    localparam logic [4:0] GRP_TRIG = 5'h03; // 0x180 trigger words
    localparam logic [4:0] GRP_DUAL = 5'h04; // 0x200 dual-edge words
    localparam logic [4:0] GRP_MASK = 5'h05; // 0x280 mask readback
    localparam logic [4:0] GRP_MSET = 5'h06; // 0x300 write-one enable
    localparam logic [4:0] GRP_MCLR = 5'h07; // 0x380 write-one disable
    localparam logic [4:0] GRP_PEND = 5'h08; // 0x400 pending readback
    localparam logic [4:0] WORD_CFG   = 5'd0;
    localparam logic [4:0] WORD_WEDGE = 5'd1;
endpackage

// File: rtl/sirq_regs.sv
`timescale 1ns/1ps
// Module: sirq_regs
// Holds the per-source sense, mask and routing registers, decodes the
// write-edge command into one-cycle pulses, and muxes read data.
// Assumes: NUM_SRC <= 256 (8-bit source number), 12-bit byte address,
// single-cycle writes, combinational reads.
module sirq_regs
    import sirq_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int NUM_CORE = 2,
    parameter int NUM_PIN  = 2,
    parameter int ADDR_W   = 12,
    parameter int CW       = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1,
    parameter int PW       = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wen,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    input  logic [NUM_SRC-1:0]            pend_i,
    output logic [NUM_SRC-1:0]            pol_o,
    output logic [NUM_SRC-1:0]            trig_o,
    output logic [NUM_SRC-1:0]            dual_o,
    output logic [NUM_SRC-1:0]            mask_o,
    output logic [NUM_SRC-1:0]            wedge_set_o,
    output logic [NUM_SRC-1:0]            wedge_clr_o,
    output logic [NUM_SRC-1:0]            pin_vld_o,
    output logic [NUM_SRC-1:0][PW-1:0]    pin_sel_o,
    output logic [NUM_SRC-1:0][CW-1:0]    core_sel_o
);
    localparam logic [31:0] CFG_WORD = (32'(NUM_SRC / 8 - 1) << 16) | 32'(NUM_CORE - 1);

    logic [4:0] grp;
    logic [4:0] widx;
    logic [7:0] sidx;
    logic       map_sel;
    logic       wedge_hit;
    logic       unused_bits;

    assign grp       = bus_addr[11:7];
    assign widx      = bus_addr[6:2];
    assign sidx      = bus_addr[9:2];
    assign map_sel   = bus_addr[11];
    assign wedge_hit = bus_wen && !map_sel && grp == GRP_CTL && widx == WORD_WEDGE;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[30:8]};

    // Decode the write-edge command into per-source set/clear pulses.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            wedge_set_o[i] = wedge_hit && bus_wdata[31] && bus_wdata[7:0] == 8'(i);
            wedge_clr_o[i] = wedge_hit && !bus_wdata[31] && bus_wdata[7:0] == 8'(i);
        end
    end

    // Update configuration, mask and routing state on bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_o      <= '1;
            trig_o     <= '0;
            dual_o     <= '0;
            mask_o     <= '0;
            pin_vld_o  <= '0;
            pin_sel_o  <= '0;
            core_sel_o <= '0;
        end else if (bus_wen) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (!map_sel && widx == 5'(i / 32)) begin
                    case (grp)
                        GRP_POL:  pol_o[i]  <= bus_wdata[i % 32];
                        GRP_TRIG: trig_o[i] <= bus_wdata[i % 32];
                        GRP_DUAL: dual_o[i] <= bus_wdata[i % 32];
                        GRP_MSET: if (bus_wdata[i % 32]) mask_o[i] <= 1'b1;
                        GRP_MCLR: if (bus_wdata[i % 32]) mask_o[i] <= 1'b0;
                        default: ;
                    endcase
                end
                if (map_sel && !bus_addr[10] && sidx == 8'(i)) begin
                    pin_vld_o[i] <= bus_wdata[31];
                    pin_sel_o[i] <= bus_wdata[PW-1:0];
                end
                if (map_sel && bus_addr[10] && sidx == 8'(i) &&
                    32'(bus_wdata[7:0]) < NUM_CORE) begin
                    core_sel_o[i] <= bus_wdata[CW-1:0];
                end
            end
        end
    end

    // Return the addressed register on the read port.
    always_comb begin
        bus_rdata = '0;
        if (map_sel) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (sidx == 8'(i)) begin
                    if (bus_addr[10]) begin
                        bus_rdata[CW-1:0] = core_sel_o[i];
                    end else begin
                        bus_rdata[31]     = pin_vld_o[i];
                        bus_rdata[PW-1:0] = pin_sel_o[i];
                    end
                end
            end
        end else if (grp == GRP_CTL) begin
            if (widx == WORD_CFG) bus_rdata = CFG_WORD;
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (widx == 5'(i / 32)) begin
                    case (grp)
                        GRP_POL:  bus_rdata[i % 32] = pol_o[i];
                        GRP_TRIG: bus_rdata[i % 32] = trig_o[i];
                        GRP_DUAL: bus_rdata[i % 32] = dual_o[i];
                        GRP_MASK: bus_rdata[i % 32] = mask_o[i];
                        GRP_PEND: bus_rdata[i % 32] = pend_i[i];
                        default: ;
                    endcase
                end
            end
        end
    end

    AST_MASK_BY_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o != $past(mask_o)) |-> $past(bus_wen && !map_sel && (grp == GRP_MSET || grp == GRP_MCLR))); // R6
endmodule

// File: rtl/sirq_src_cond.sv
`timescale 1ns/1ps
// Module: sirq_src_cond
// Synchronizes each source through two flops, detects edges against a
// registered copy, and forms the pending state: the level for level
// sources, and a sticky latch for edge sources.
// Assumes: wedge pulses last one cycle. An input edge and a clear in the
// same cycle leave the latch set. The latch is held clear while a source
// is level-sensed.
module sirq_src_cond #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] pol,
    input  logic [NUM_SRC-1:0] trig,
    input  logic [NUM_SRC-1:0] dual,
    input  logic [NUM_SRC-1:0] wedge_set,
    input  logic [NUM_SRC-1:0] wedge_clr,
    output logic [NUM_SRC-1:0] pend_o
);
    logic [NUM_SRC-1:0] sync1, sync2, prev;
    logic [NUM_SRC-1:0] rise, fall, edge_hit;
    logic [NUM_SRC-1:0] latch_q;

    // Two-flop synchronizer plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
            prev  <= '0;
        end else begin
            sync1 <= irq_in;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    assign rise     = sync2 & ~prev;
    assign fall     = ~sync2 & prev;
    assign edge_hit = (dual & (rise | fall)) | (~dual & ((pol & rise) | (~pol & fall)));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        // Sticky pending latch of one edge-sensed source.
        always_ff @(posedge clk) begin
            if (!rst_n || !trig[i]) begin
                latch_q[i] <= 1'b0;
            end else if (edge_hit[i] || wedge_set[i]) begin
                latch_q[i] <= 1'b1;
            end else if (wedge_clr[i]) begin
                latch_q[i] <= 1'b0;
            end
        end

        assign pend_o[i] = trig[i] ? latch_q[i] : (sync2[i] == pol[i]);

        AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (trig[i] && $past(trig[i]) && $past(pend_o[i]) && !$past(wedge_clr[i])) |-> pend_o[i]); // R4
        AST_WEDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (trig[i] && $past(trig[i] && wedge_set[i])) |-> pend_o[i]); // R7
        AST_LEVEL_IGNORES_WEDGE: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig[i] && $past(!trig[i]) && $stable(sync2[i]) && $stable(pol[i])) |-> $stable(pend_o[i])); // R7
    end
endmodule

// File: rtl/sirq_core_merge.sv
`timescale 1ns/1ps
// Module: sirq_core_merge
// ORs every pending, enabled, validly mapped source onto the output bit
// core*NUM_PIN+pin and registers the result.
// Assumes: each core index is below NUM_CORE and each pin index below NUM_PIN.
module sirq_core_merge #(
    parameter int NUM_SRC  = 16,
    parameter int NUM_CORE = 2,
    parameter int NUM_PIN  = 2,
    parameter int CW       = 1,
    parameter int PW       = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         pend,
    input  logic [NUM_SRC-1:0]         mask,
    input  logic [NUM_SRC-1:0]         pin_vld,
    input  logic [NUM_SRC-1:0][PW-1:0] pin_sel,
    input  logic [NUM_SRC-1:0][CW-1:0] core_sel,
    output logic [NUM_CORE*NUM_PIN-1:0] core_irq_o
);
    localparam int NOUT = NUM_CORE * NUM_PIN;

    logic [NUM_SRC-1:0] live;
    logic [NOUT-1:0]    nxt;

    assign live = pend & mask & pin_vld;

    // OR each live source onto the output line it is mapped to.
    always_comb begin
        nxt = '0;
        for (int c = 0; c < NUM_CORE; c++) begin
            for (int p = 0; p < NUM_PIN; p++) begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (live[i] && core_sel[i] == CW'(c) && pin_sel[i] == PW'(p)) begin
                        nxt[c * NUM_PIN + p] = 1'b1;
                    end
                end
            end
        end
    end

    // Register the core outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) core_irq_o <= '0;
        else        core_irq_o <= nxt;
    end

    AST_IDLE_OUTPUTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(|(pend & mask)) |-> (core_irq_o == '0)); // R9

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        AST_LIVE_REACHES_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
            $past(live[i]) |-> core_irq_o[$past(int'(core_sel[i])) * NUM_PIN + $past(int'(pin_sel[i]))]); // R8
    end
endmodule

// File: rtl/shared_irq_router.sv
`timescale 1ns/1ps
// Module: shared_irq_router
// Top of the shared interrupt router: register file, per-source
// conditioning, and per-core output merging.
// Assumes: NUM_SRC is a multiple of 8 and at most 256; the bus is a
// single-cycle write with combinational read.
module shared_irq_router #(
    parameter int NUM_SRC  = 16,
    parameter int NUM_CORE = 2,
    parameter int NUM_PIN  = 2,
    parameter int ADDR_W   = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SRC-1:0]           irq_in,
    input  logic                         bus_wen,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    output logic [NUM_CORE*NUM_PIN-1:0]  core_irq
);
    localparam int CW = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1;
    localparam int PW = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1;

    logic [NUM_SRC-1:0]         pol, trig, dual, mask, pend;
    logic [NUM_SRC-1:0]         wedge_set, wedge_clr, pin_vld;
    logic [NUM_SRC-1:0][PW-1:0] pin_sel;
    logic [NUM_SRC-1:0][CW-1:0] core_sel;

    sirq_regs #(
        .NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN),
        .ADDR_W(ADDR_W), .CW(CW), .PW(PW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wen(bus_wen), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pend_i(pend), .pol_o(pol), .trig_o(trig), .dual_o(dual), .mask_o(mask),
        .wedge_set_o(wedge_set), .wedge_clr_o(wedge_clr),
        .pin_vld_o(pin_vld), .pin_sel_o(pin_sel), .core_sel_o(core_sel)
    );

    sirq_src_cond #(.NUM_SRC(NUM_SRC)) u_cond (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .pol(pol), .trig(trig), .dual(dual),
        .wedge_set(wedge_set), .wedge_clr(wedge_clr), .pend_o(pend)
    );

    sirq_core_merge #(
        .NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN), .CW(CW), .PW(PW)
    ) u_merge (
        .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask),
        .pin_vld(pin_vld), .pin_sel(pin_sel), .core_sel(core_sel), .core_irq_o(core_irq)
    );
endmodule

// File: tb/tb_shared_irq_router.sv
`timescale 1ns/1ps
// Bench: sweeps sense modes over all 16 sources of a 2-core, 2-pin
// configuration and computes expected pending and output words from the
// requirements.
module tb_shared_irq_router;
    localparam int NS = 16;
    localparam int NC = 2;
    localparam int NP = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS-1:0]     irq_in = '0;
    logic              bus_wen = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NC*NP-1:0]  core_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int b_core [NS];
    int b_pin  [NS];
    bit b_vld  [NS];

    shared_irq_router #(.NUM_SRC(NS), .NUM_CORE(NC), .NUM_PIN(NP), .ADDR_W(12)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wen(bus_wen),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_irq(core_irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
    endtask

    function automatic logic [NC*NP-1:0] exp_out(input logic [NS-1:0] p, input logic [NS-1:0] m);
        logic [NC*NP-1:0] r = '0;
        for (int i = 0; i < NS; i++)
            if (p[i] && m[i] && b_vld[i]) r[b_core[i] * NP + b_pin[i]] = 1'b1;
        return r;
    endfunction

    task automatic map_src(input int i, input int c, input int p, input bit v);
        wr(12'h800 + 12'(4 * i), {v, 23'd0, 8'(p)});
        wr(12'hC00 + 12'(4 * i), 32'(c));
        if (c < NC) b_core[i] = c;
        b_pin[i] = p;
        b_vld[i] = v;
    endtask

    initial begin
        logic [31:0] d;
        logic [NS-1:0] ep;
        for (int i = 0; i < NS; i++) begin b_core[i] = 0; b_pin[i] = 0; b_vld[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(12'h100, d); chk("R1 polarity", d, 32'h0000_FFFF);
        rd(12'h180, d); chk("R1 trigger", d, 32'h0);
        rd(12'h280, d); chk("R1 mask", d, 32'h0);
        rd(12'h400, d); chk("R1 pending", d, 32'h0);
        rd(12'h800, d); chk("R1 pin map", d, 32'h0);
        chk("R1 outputs", 32'(core_irq), 32'h0);

        // R2 configuration word
        rd(12'h000, d); chk("R2 config", d, (32'(NS / 8 - 1) << 16) | 32'(NC - 1));

        // R8 routing setup: source i to core i%2, pin (i/2)%2
        for (int i = 0; i < NS; i++) map_src(i, i % 2, (i / 2) % 2, 1'b1);
        rd(12'hC00 + 12'd12, d); chk("R10 core readback", d, 32'd1);
        rd(12'h800 + 12'd8, d); chk("R8 pin readback", d, 32'h8000_0001);

        // R6 write-one mask semantics
        wr(12'h300, 32'h0000_FFFF); rd(12'h280, d); chk("R6 set all", d, 32'h0000_FFFF);
        wr(12'h380, 32'h0000_0005); rd(12'h280, d); chk("R6 clear two", d, 32'h0000_FFFA);
        wr(12'h300, 32'h0); rd(12'h280, d); chk("R6 zero bits no effect", d, 32'h0000_FFFA);
        wr(12'h380, 32'h0); rd(12'h280, d); chk("R6 zero clear no effect", d, 32'h0000_FFFA);
        wr(12'h300, 32'h0000_0005);

        // R3 and R9 exact latency on source 6 (core 0, pin 1 -> bit 1)
        @(negedge clk) irq_in = 16'h0040;
        @(posedge clk); @(posedge clk);
        rd(12'h400, d); chk("R3 pending after two edges", d, 32'h0000_0040);
        chk("R9 output not yet", 32'(core_irq), 32'h0);
        @(negedge clk); chk("R9 output one edge later", 32'(core_irq), 32'h2);
        @(negedge clk) irq_in = '0; settle();

        // R3 and R8 level sweep, both polarities
        for (int i = 0; i < NS; i++) begin
            @(negedge clk) irq_in = NS'(1) << i;
            settle();
            rd(12'h400, d); chk("R3 active-high pending", d, 32'(NS'(1) << i));
            chk("R8 route active-high", 32'(core_irq), 32'(exp_out(NS'(1) << i, '1)));
        end
        wr(12'h100, 32'h0);
        for (int i = 0; i < NS; i++) begin
            @(negedge clk) irq_in = NS'(1) << i;
            settle();
            ep = ~(NS'(1) << i);
            rd(12'h400, d); chk("R3 active-low pending", d, 32'(ep));
            chk("R8 route active-low", 32'(core_irq), 32'(exp_out(ep, '1)));
        end
        @(negedge clk) irq_in = '0;
        wr(12'h100, 32'h0000_FFFF); settle();

        // R11 pending visible while masked
        @(negedge clk) irq_in = 16'h0300;
        wr(12'h380, 32'h0000_0100); settle();
        rd(12'h400, d); chk("R11 pending while masked", d, 32'h0000_0300);
        chk("R8 masked source silent", 32'(core_irq), 32'(exp_out(16'h0300, 16'hFEFF)));
        @(negedge clk) irq_in = '0;
        wr(12'h300, 32'h0000_0100); settle();

        // R4 rising-edge sweep with clear via write-edge
        wr(12'h180, 32'h0000_FFFF);
        for (int i = 0; i < NS; i++) begin
            @(negedge clk) irq_in = NS'(1) << i;
            settle();
            @(negedge clk) irq_in = '0;
            settle();
            rd(12'h400, d); chk("R4 rising latched", d, 32'(NS'(1) << i));
            chk("R8 edge routed", 32'(core_irq), 32'(exp_out(NS'(1) << i, '1)));
            wr(12'h004, 32'(i)); settle();
            rd(12'h400, d); chk("R7 clear acks edge", d, 32'h0);
        end

        // R4 falling edge with polarity 0 on source 5
        wr(12'h100, 32'h0);
        @(negedge clk) irq_in = 16'h0020; settle();
        rd(12'h400, d); chk("R4 falling: rise ignored", d, 32'h0);
        @(negedge clk) irq_in = '0; settle();
        rd(12'h400, d); chk("R4 falling latched", d, 32'h0000_0020);
        wr(12'h004, 32'd5); settle();

        // R5 dual edge, polarity irrelevant
        for (int pv = 0; pv < 2; pv++) begin
            wr(12'h100, pv ? 32'h0000_FFFF : 32'h0);
            wr(12'h200, 32'h0000_FFFF);
            @(negedge clk) irq_in = 16'h0008; settle();
            rd(12'h400, d); chk("R5 dual rise", d, 32'h0000_0008);
            wr(12'h004, 32'd3); settle();
            rd(12'h400, d); chk("R5 dual cleared", d, 32'h0);
            @(negedge clk) irq_in = '0; settle();
            rd(12'h400, d); chk("R5 dual fall", d, 32'h0000_0008);
            wr(12'h004, 32'd3); settle();
        end
        wr(12'h200, 32'h0); wr(12'h100, 32'h0000_FFFF);

        // R7 software set, level source untouched, out-of-range number
        wr(12'h180, 32'h0000_FEFF);
        wr(12'h004, 32'h8000_0007); settle();
        rd(12'h400, d); chk("R7 set edge source", d, 32'h0000_0080);
        chk("R7 set reaches core", 32'(core_irq), 32'(exp_out(16'h0080, '1)));
        wr(12'h004, 32'h8000_0008); settle();
        rd(12'h400, d); chk("R7 level source ignores set", d, 32'h0000_0080);
        wr(12'h004, 32'h8000_00C8); wr(12'h004, 32'h0000_00C8); settle();
        rd(12'h400, d); chk("R7 out-of-range number ignored", d, 32'h0000_0080);

        // R10 reroute source 7 (core 1 pin 1 -> bit 3) to core 0 (bit 1)
        wr(12'h380, 32'h0000_FF7F); settle();
        chk("R10 before reroute", 32'(core_irq), 32'h8);
        map_src(7, 0, 1, 1'b1); settle();
        chk("R10 after reroute", 32'(core_irq), 32'h2);
        map_src(7, 5, 1, 1'b1); settle();
        rd(12'hC00 + 12'd28, d); chk("R10 bad core ignored", d, 32'd0);
        chk("R10 bad core output", 32'(core_irq), 32'h2);

        // R8 invalid pin map silences the source
        map_src(7, 0, 1, 1'b0); settle();
        chk("R8 invalid pin map", 32'(core_irq), 32'h0);
        rd(12'h400, d); chk("R11 still pending", d, 32'h0000_0080);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule